// File: doc/BRIEF.md
# Level-1 Trigger Latency Pipeline

This block holds a short history of per-bunch hit words while the trigger decision is being formed upstream. Every bunch-crossing clock it stores the current hit word in a circular array, so the array always holds the most recent bunches in arrival order. When a Level-1 accept strobe arrives, the block reads back a window of three consecutive stored bunches. The window sits a programmable number of bunches in the past. It sends the three words out on three successive clocks, each tagged with its position in the window.

The latency is set by a 7-bit depth input, so 128 settings are available. A new latency can be applied during a run by changing this input. The block takes the new value only while no window is being read out. After an accept, the block holds off further accepts for two clocks. An accept that arrives in that dead time is dropped, and a counter of dropped accepts advances. An accept on the third clock is taken, and its window follows the previous one with no gap.

Top module: `l1_latency_pipe`

## Requirements
- R1: While reset is asserted and right after it, `win_valid_o`, `busy_o` and `rej_cnt_o` are all zero.
- R2: Exactly one hit word is stored per clock. For an accept taken at clock edge t, the window holds the hit words of bunches t-(D+3), t-(D+2) and t-(D+1). Here bunch n is the word sampled at edge n, and D is the depth in force at edge t.
- R3: The three window words appear on the clocks after edges t+1, t+2 and t+3, with `win_valid_o` high. `win_slot_o` is 0, 1 and 2 on those clocks, from the earliest bunch to the latest. `win_valid_o` is low whenever no window word is being emitted.
- R4: The depth covers its full unsigned 7-bit range: D=0 gives an earliest bunch of t-3, and D=127 gives an earliest bunch of t-130.
- R5: After an accepted L1A, `busy_o` is high for exactly two clocks. An L1A sampled while `busy_o` is high starts no window.
- R6: Each L1A dropped because of `busy_o` raises `rej_cnt_o` by one. The counter holds at all other times and is cleared only by reset.
- R7: An L1A on the third edge after an accept is taken. Its slot 0 word follows the previous slot 2 word on the very next clock.
- R8: `depth_i` is registered only on edges where no readout is active; a change during a readout applies to later windows. The depth used by an accept is the value registered before that accept's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | DATA_W | Hit word of the current bunch |
| l1a_i | input | 1 | Level-1 accept strobe |
| depth_i | input | DEPTH_W | Latency setting D |
| win_data_o | output | DATA_W | Window word |
| win_slot_o | output | 2 | Position of the word in the window |
| win_valid_o | output | 1 | Window word strobe |
| busy_o | output | 1 | Dead-time flag |
| rej_cnt_o | output | CNT_W | Count of dropped L1As |

## Verification
Each hit word carries its own bunch number, so a read pointer that is off by one shows up at once as a shifted word. The depth extremes 0 and 127 are exercised directly; a design that miscomputed the latency offset, or that wrapped the pointer modulo the wrong size, would return the wrong bunch at one end. Bursts of L1As in adjacent clocks check two things: that exactly two are dropped and counted, and that the third is taken with no gap. A design with the wrong dead-time length would drop or counterfeit a window there. The bench changes the depth in the middle of a readout and also on the edge of an accept. A design that sampled the depth at the wrong time would read a window at the new latency too early.

// File: rtl/l1p_pkg.sv
package l1p_pkg;
  localparam int WIN_LEN = 3;
  localparam int DEAD_BX = WIN_LEN - 1;
  localparam int SLOT_W  = 2;
endpackage

// File: rtl/l1p_ring.sv
module l1p_ring #(
  parameter int DATA_W = 16,
  parameter int AW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] hit_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [AW-1:0]     wr_ptr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int N = 1 << AW;

  logic [DATA_W-1:0] mem_q [N];
  logic [AW-1:0]     wr_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_ptr_q <= '0;
    else         wr_ptr_q <= wr_ptr_q + AW'(1);
  end

  always_ff @(posedge clk_i) mem_q[wr_ptr_q] <= hit_i;

  assign wr_ptr_o  = wr_ptr_q;
  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/l1p_seq.sv
module l1p_seq
  import l1p_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH_W = 7,
  parameter int AW      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l1a_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [AW-1:0]     wr_ptr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              valid_o
);
  logic              active_q;
  logic [SLOT_W-1:0] slot_q;
  logic [AW-1:0]     base_q;
  logic [DEPTH_W-1:0] depth_q;
  logic              accept, last;
  logic [AW-1:0]     lat;

  assign busy_o    = active_q && (slot_q < SLOT_W'(DEAD_BX));
  assign accept    = l1a_i && !busy_o;
  assign last      = slot_q == SLOT_W'(WIN_LEN - 1);
  assign lat       = AW'(depth_q) + AW'(WIN_LEN);
  assign rd_addr_o = base_q + AW'(slot_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      base_q   <= '0;
      depth_q  <= '0;
      data_o   <= '0;
      slot_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      // latency only moves between readouts
      if (!active_q) depth_q <= depth_i;
      if (accept) begin
        active_q <= 1'b1;
        slot_q   <= '0;
        base_q   <= wr_ptr_i - lat;
      end else if (active_q) begin
        if (last) active_q <= 1'b0;
        else      slot_q   <= slot_q + SLOT_W'(1);
      end
      valid_o <= active_q;
      if (active_q) begin
        data_o <= rd_data_i;
        slot_o <= slot_q;
      end
    end
  end
endmodule

// File: rtl/l1p_rejcnt.sv
module l1p_rejcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drop_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (drop_i) count_o <= count_o + CNT_W'(1);
  end
endmodule

// File: rtl/l1_latency_pipe.sv
module l1_latency_pipe
  import l1p_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH_W = 7,
  parameter int CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  hit_i,
  input  logic               l1a_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [DATA_W-1:0]  win_data_o,
  output logic [SLOT_W-1:0]  win_slot_o,
  output logic               win_valid_o,
  output logic               busy_o,
  output logic [CNT_W-1:0]   rej_cnt_o
);
  // one extra address bit covers max depth plus the window
  localparam int AW = DEPTH_W + 1;

  logic [AW-1:0]     wr_ptr, rd_addr;
  logic [DATA_W-1:0] rd_data;

  l1p_ring #(.DATA_W(DATA_W), .AW(AW)) u_ring (
    .clk_i, .rst_ni, .hit_i,
    .rd_addr_i(rd_addr), .wr_ptr_o(wr_ptr), .rd_data_o(rd_data)
  );

  l1p_seq #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W), .AW(AW)) u_seq (
    .clk_i, .rst_ni, .l1a_i, .depth_i,
    .wr_ptr_i(wr_ptr), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .busy_o, .data_o(win_data_o), .slot_o(win_slot_o), .valid_o(win_valid_o)
  );

  l1p_rejcnt #(.CNT_W(CNT_W)) u_rej (
    .clk_i, .rst_ni, .drop_i(l1a_i && busy_o), .count_o(rej_cnt_o)
  );
endmodule

// File: rtl/l1p_chk.sv
module l1p_chk #(
  parameter int DATA_W  = 16,
  parameter int DEPTH_W = 7,
  parameter int CNT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [DATA_W-1:0]  hit_i,
  input logic               l1a_i,
  input logic [DEPTH_W-1:0] depth_i,
  input logic [DATA_W-1:0]  win_data_o,
  input logic [1:0]         win_slot_o,
  input logic               win_valid_o,
  input logic               busy_o,
  input logic [CNT_W-1:0]   rej_cnt_o
);
  assert_dead_two_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1a_i && !busy_o) |=> busy_o ##1 busy_o ##1 !busy_o);

  assert_first_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1a_i && !busy_o) |=> ##1 (win_valid_o && win_slot_o == 2'd0));

  assert_slot01_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && win_slot_o == 2'd0) |=> (win_valid_o && win_slot_o == 2'd1));

  assert_slot12_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && win_slot_o == 2'd1) |=> (win_valid_o && win_slot_o == 2'd2));

  assert_slot_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> win_slot_o != 2'd3);

  assert_rej_inc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1a_i && busy_o) |=> rej_cnt_o == $past(rej_cnt_o) + CNT_W'(1));

  assert_rej_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l1a_i && busy_o) |=> $stable(rej_cnt_o));
endmodule

bind l1_latency_pipe l1p_chk #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_i), .l1a_i(l1a_i), .depth_i(depth_i),
  .win_data_o(win_data_o), .win_slot_o(win_slot_o), .win_valid_o(win_valid_o),
  .busy_o(busy_o), .rej_cnt_o(rej_cnt_o)
);

// File: tb/l1_latency_pipe_test.sv
module l1_latency_pipe_test;
  localparam int DW = 16, DPW = 7, CW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic [DW-1:0]  hit;
  logic           l1a;
  logic [DPW-1:0] depth;
  logic [DW-1:0]  win_data;
  logic [1:0]     win_slot;
  logic           win_valid, busy;
  logic [CW-1:0]  rej_cnt;

  l1_latency_pipe #(.DATA_W(DW), .DEPTH_W(DPW), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .l1a_i(l1a), .depth_i(depth),
    .win_data_o(win_data), .win_slot_o(win_slot), .win_valid_o(win_valid),
    .busy_o(busy), .rej_cnt_o(rej_cnt)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] q_data[$];
  int            q_slot[$];
  int            dead = 0, act_left = 0, rej_m = 0;
  logic [DPW-1:0] dq = '0;
  bit            pend = 0;
  logic [DW-1:0] pend_base;
  string         tag = "R2";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_word(input logic [DW-1:0] h, input logic [DPW-1:0] d);
    return h - DW'(d) - DW'(3);
  endfunction

  task automatic model_reset();
    q_data.delete(); q_slot.delete();
    dead = 0; act_left = 0; rej_m = 0; dq = '0; pend = 0;
  endtask

  // check outputs of the previous edge, then drive the next edge
  task automatic tick(input bit l, input logic [DPW-1:0] d);
    @(negedge clk);
    if (q_data.size() > 0) begin
      logic [DW-1:0] e = q_data.pop_front();
      int s = q_slot.pop_front();
      chk(win_valid == 1'b1, "R3 valid", win_valid, 1);
      chk(win_data == e, tag, win_data, e);
      chk(int'(win_slot) == s, "R3 slot", win_slot, s);
    end else begin
      chk(win_valid == 1'b0, "R3 idle", win_valid, 0);
    end
    chk(busy == (dead > 0), "R5 busy", busy, dead > 0);
    chk(int'(rej_cnt) == rej_m, "R6 count", rej_cnt, rej_m);
    if (pend) begin
      for (int i = 0; i < 3; i++) begin
        q_data.push_back(pend_base + DW'(i));
        q_slot.push_back(i);
      end
      pend = 0;
    end
    hit = hit + DW'(1);
    l1a = l;
    depth = d;
    if (l && dead == 0) begin
      pend = 1;
      pend_base = exp_word(hit, dq);
    end else if (l) rej_m++;
    dead = (l && dead == 0) ? 2 : (dead > 0 ? dead - 1 : 0);
    if (act_left == 0) dq = d;
    act_left = pend ? 3 : (act_left > 0 ? act_left - 1 : 0);
  endtask

  task automatic do_reset(input logic [DPW-1:0] d);
    @(negedge clk);
    rst_n = 1'b0; l1a = 1'b0; depth = d;
    model_reset();
    @(negedge clk);
    chk(win_valid == 1'b0 && busy == 1'b0, "R1 outputs", {win_valid, busy}, 0);
    chk(rej_cnt == '0, "R1 rej", rej_cnt, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 140; i++) tick(0, d);
  endtask

  initial begin
    int unsigned seed;
    logic [DPW-1:0] rd;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; hit = '0; l1a = 1'b0; depth = 7'd20;
    do_reset(7'd20);

    tag = "R2 basic";
    tick(1, 7'd20); repeat (6) tick(0, 7'd20);

    tag = "R4 min";
    repeat (4) tick(0, 7'd0); tick(1, 7'd0); repeat (5) tick(0, 7'd0);
    tag = "R4 max";
    repeat (4) tick(0, 7'd127); tick(1, 7'd127); repeat (5) tick(0, 7'd127);

    tag = "R7 back2back";  // two drops, then accept on third edge (R5, R6)
    repeat (4) tick(0, 7'd9);
    repeat (8) tick(1, 7'd9);
    repeat (5) tick(0, 7'd9);

    tag = "R8 depth mid-readout";
    repeat (4) tick(0, 7'd10);
    tick(1, 7'd10); tick(0, 7'd50); tick(0, 7'd50); tick(1, 7'd50);
    repeat (6) tick(0, 7'd50);
    tag = "R8 depth on accept edge";
    tick(1, 7'd90); repeat (5) tick(0, 7'd90); tick(1, 7'd90); repeat (5) tick(0, 7'd90);

    tag = "R2 random";
    rd = 7'd33;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) rd = 7'($urandom_range(0, 127));
      tick($urandom_range(0, 2) == 0, rd);
    end
    repeat (6) tick(0, rd);

    tag = "R1 reset";
    do_reset(7'd5);
    tick(1, 7'd5); repeat (5) tick(0, 7'd5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule